// File: doc/BRIEF.md
# Single-Level Page-Table Walking Address Translator

This block sits between a processor's memory port and a cache port. A processor request carries a 32-bit virtual address, a read/write flag and a translate flag. When the translate flag is set, a small controller looks up one entry of a page table kept in memory. The controller first checks the page number against a table-length register. It then fetches the entry through the same cache port that later carries the data access. It checks the entry's valid and permission bits, builds the physical address and performs the access. A request without the translate flag uses its address unchanged.

The processor pulses `cpu_req` for one cycle while the block is idle. The block latches the address, the flags and the write data in that cycle. It then raises `cpu_busy` until the transaction ends. A table-length fault or an entry fault ends the walk early. The block then drops busy and pulses a fault output, and `exc_vaddr` holds the faulting virtual address for a handler.

Top module: `pt_walk_xlate`

## Requirements
- R1: During and right after synchronous reset (`rst_n` low), `cpu_busy`, `mem_rd`, `mem_wr`, `exc_len` and `exc_pte` are all 0, including when reset cuts a transaction short.
- R2: A request is taken only when `cpu_busy` is low. Address, flags and write data are captured in that cycle. A `cpu_req` pulse or input change while busy has no effect on the running transaction and starts no new one.
- R3: A translated request reads its table entry at byte address {`pt_origin`, 12 zero bits} + 4 × page number, where the page number is virtual address bits [31:12].
- R4: If the page number is greater than or equal to `pt_length`, the block makes no memory access. Busy is high for exactly 1 cycle, and `exc_len` pulses in the first idle cycle with `exc_vaddr` equal to the request address.
- R5: Entry bit 2 is valid, bit 1 is write permission and bit 0 is read permission. A clear valid bit, a read without bit 0 or a write without bit 1 pulses `exc_pte` after the entry read, with no data access. Busy is high for L+3 cycles, where L is the number of cycles the cache holds `mem_busy` for each strobe.
- R6: A translated access that passes its checks uses the address {entry bits [31:12], virtual bits [11:0]}. Busy is high for 2L+4 cycles.
- R7: An untranslated request makes exactly one access, at the request address. Busy is high for L+2 cycles.
- R8: `mem_rd` or `mem_wr` stays asserted with a stable `mem_addr` while `mem_busy` is high. A strobe is never asserted while `cpu_busy` is low.
- R9: A completed read returns the cache data on `cpu_rdata` in the first idle cycle. A completed write presents the captured write data on `mem_wdata`.
- R10: `exc_len` and `exc_pte` are never high together, and each lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | One-cycle request strobe, honoured only when idle |
| cpu_xlate | input | 1 | 1: translate through the page table |
| cpu_wr | input | 1 | 1: write, 0: read |
| cpu_addr | input | 32 | Virtual (or untranslated) address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data of the last completed read |
| cpu_busy | output | 1 | Transaction in progress |
| pt_origin | input | 20 | Page-table base, in 4 KB units |
| pt_length | input | 20 | Number of table entries |
| exc_len | output | 1 | Page-number-over-length fault pulse |
| exc_pte | output | 1 | Invalid or forbidden entry fault pulse |
| exc_vaddr | output | 32 | Virtual address of the last request |
| mem_rd | output | 1 | Cache read strobe |
| mem_wr | output | 1 | Cache write strobe |
| mem_addr | output | 32 | Cache byte address |
| mem_wdata | output | 32 | Cache write data |
| mem_rdata | input | 32 | Cache read data |
| mem_busy | input | 1 | Cache still working on the current strobe |

## Verification
Each result depends on how many states the controller passes through. A length fault is due 1 cycle after acceptance. An entry fault is due after L+3 busy cycles, a translated access after 2L+4 and an untranslated one after L+2, where L is the cache model's stall setting for that vector. The bench counts the busy cycles at each falling edge and compares the count against these formulas. It reads `cpu_rdata`, the fault pulses and the cache model's access log in the first idle cycle, and checks one cycle later that the pulses are gone. Access counts per transaction (0, 1 or 2) confirm that faulting requests touch no data.

// File: rtl/pt_xlate_pkg.sv
// Package: shared types of the page-table walking translator.
// Assumes one level of table and entries as wide as the data bus.
package pt_xlate_pkg;

    // Controller states; the order follows the walk sequence
    typedef enum logic [2:0] {
        WS_IDLE,
        WS_ADD,
        WS_SETA,
        WS_READPTE,
        WS_COMPPA,
        WS_READ,
        WS_WRITE
    } walk_state_t;

    // Source selected into the address register
    typedef enum logic [1:0] {
        AR_RAW,
        AR_PTE,
        AR_PHYS
    } ar_src_t;

    // Datapath controls issued by the controller
    typedef struct packed {
        logic    take_req;
        logic    ar_load;
        ar_src_t ar_src;
        logic    dr_load;
    } walk_ctl_t;

    // Flag positions inside a table entry
    localparam int PTE_V_BIT = 2;
    localparam int PTE_W_BIT = 1;
    localparam int PTE_R_BIT = 0;

endpackage

// File: rtl/pt_entry_check.sv
// Module: decides whether a fetched entry allows the requested access.
// Assumes flags arrive as {valid, write, read}. Purely combinational.
module pt_entry_check
    import pt_xlate_pkg::*;
(
    input  logic [2:0] flags,
    input  logic       is_write,
    output logic       fault
);

    logic ok_valid;
    logic ok_right;

    // Split the flag checks, then combine them into a single fault
    always_comb begin
        ok_valid = flags[PTE_V_BIT];
        ok_right = is_write ? flags[PTE_W_BIT] : flags[PTE_R_BIT];
        fault    = !(ok_valid && ok_right);
    end

endmodule

// File: rtl/pt_walk_datapath.sv
// Module: request latches, address and data registers of the walker.
// Assumes the entry width equals DATA_W and ADDR_W == DATA_W.
module pt_walk_datapath
    import pt_xlate_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int OFS_W  = 12,
    localparam int PIDX_W = ADDR_W - OFS_W
)(
    input  logic              clk,
    input  logic              rst_n,
    input  walk_ctl_t         ctl,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [PIDX_W-1:0] pt_origin,
    input  logic [PIDX_W-1:0] pt_length,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              req_wr,
    output logic              len_fault,
    output logic              pte_fault,
    output logic [ADDR_W-1:0] ar,
    output logic [DATA_W-1:0] dr,
    output logic [ADDR_W-1:0] va_q,
    output logic [DATA_W-1:0] wdata_q
);

    localparam int ESH   = $clog2(DATA_W / 8);
    localparam int PAD_W = ADDR_W - PIDX_W - ESH;

    logic [PIDX_W-1:0] page_idx;
    logic [ADDR_W-1:0] pte_addr;
    logic [ADDR_W-1:0] phys_addr;
    logic [ADDR_W-1:0] ar_next;

    // Latch the request when the controller accepts it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q    <= '0;
            req_wr  <= 1'b0;
            wdata_q <= '0;
        end else if (ctl.take_req) begin
            va_q    <= cpu_addr;
            req_wr  <= cpu_wr;
            wdata_q <= cpu_wdata;
        end
    end

    // Entry address, physical address and length comparison
    always_comb begin
        page_idx  = va_q[ADDR_W-1:OFS_W];
        pte_addr  = {pt_origin, {OFS_W{1'b0}}}
                  + {{PAD_W{1'b0}}, page_idx, {ESH{1'b0}}};
        phys_addr = {dr[DATA_W-1 -: PIDX_W], va_q[OFS_W-1:0]};
        len_fault = (page_idx >= pt_length);
    end

    // Choose the next address register value
    always_comb begin
        case (ctl.ar_src)
            AR_PTE:  ar_next = pte_addr;
            AR_PHYS: ar_next = phys_addr;
            default: ar_next = va_q;
        endcase
    end

    // Address register feeding the cache port
    always_ff @(posedge clk) begin
        if (!rst_n)
            ar <= '0;
        else if (ctl.ar_load)
            ar <= ar_next;
    end

    // Data register capturing entries and read data
    always_ff @(posedge clk) begin
        if (!rst_n)
            dr <= '0;
        else if (ctl.dr_load)
            dr <= mem_rdata;
    end

    pt_entry_check u_check (
        .flags    (dr[2:0]),
        .is_write (req_wr),
        .fault    (pte_fault)
    );

    AST_PA_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.ar_load && ctl.ar_src == AR_PHYS)
        |=> ar[OFS_W-1:0] == $past(va_q[OFS_W-1:0])); // R6

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.ar_load && ctl.ar_src == AR_PTE)
        |-> va_q[ADDR_W-1:OFS_W] < pt_length); // R4

endmodule

// File: rtl/pt_walk_fsm.sv
// Module: walk controller sequencing the table lookup and the access.
// Assumes the cache holds mem_busy high until the strobed access ends.
module pt_walk_fsm
    import pt_xlate_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cpu_req,
    input  logic      cpu_xlate,
    input  logic      req_wr,
    input  logic      len_fault,
    input  logic      pte_fault,
    input  logic      mem_busy,
    output walk_ctl_t ctl,
    output logic      mem_rd,
    output logic      mem_wr,
    output logic      cpu_busy,
    output logic      exc_len,
    output logic      exc_pte
);

    walk_state_t state;
    walk_state_t state_n;
    logic        set_len;
    logic        set_pte;

    // Next state, datapath controls and strobes
    always_comb begin
        state_n     = state;
        ctl         = '{take_req: 1'b0, ar_load: 1'b0, ar_src: AR_RAW, dr_load: 1'b0};
        mem_rd      = 1'b0;
        mem_wr      = 1'b0;
        set_len     = 1'b0;
        set_pte     = 1'b0;
        case (state)
            WS_IDLE: begin
                if (cpu_req) begin
                    ctl.take_req = 1'b1;
                    state_n      = cpu_xlate ? WS_ADD : WS_SETA;
                end
            end
            WS_ADD: begin
                ctl.ar_load = 1'b1;
                ctl.ar_src  = AR_PTE;
                if (len_fault) begin
                    ctl.ar_load = 1'b0;
                    set_len     = 1'b1;
                    state_n     = WS_IDLE;
                end else begin
                    state_n = WS_READPTE;
                end
            end
            WS_SETA: begin
                ctl.ar_load = 1'b1;
                ctl.ar_src  = AR_RAW;
                state_n     = req_wr ? WS_WRITE : WS_READ;
            end
            WS_READPTE: begin
                mem_rd = 1'b1;
                if (!mem_busy) begin
                    ctl.dr_load = 1'b1;
                    state_n     = WS_COMPPA;
                end
            end
            WS_COMPPA: begin
                if (pte_fault) begin
                    set_pte = 1'b1;
                    state_n = WS_IDLE;
                end else begin
                    ctl.ar_load = 1'b1;
                    ctl.ar_src  = AR_PHYS;
                    state_n     = req_wr ? WS_WRITE : WS_READ;
                end
            end
            WS_READ: begin
                mem_rd = 1'b1;
                if (!mem_busy) begin
                    ctl.dr_load = 1'b1;
                    state_n     = WS_IDLE;
                end
            end
            WS_WRITE: begin
                mem_wr = 1'b1;
                if (!mem_busy)
                    state_n = WS_IDLE;
            end
            default: state_n = WS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= WS_IDLE;
        else
            state <= state_n;
    end

    // One-cycle fault pulses issued on return to idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_len <= 1'b0;
            exc_pte <= 1'b0;
        end else begin
            exc_len <= set_len;
            exc_pte <= set_pte;
        end
    end

    // Processor side sees busy in every state but idle
    always_comb cpu_busy = (state != WS_IDLE);

    AST_REQ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_busy && cpu_req) |=> cpu_busy); // R2

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && mem_busy) |=> mem_rd); // R8

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && mem_busy) |=> mem_wr); // R8

    AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> cpu_busy); // R8

    AST_EXC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(exc_len && exc_pte)); // R10

    AST_EXC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_len || exc_pte) |=> !(exc_len || exc_pte)); // R10

    AST_EXC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_len || exc_pte) |-> !cpu_busy); // R4

    AST_LEN_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        exc_len |-> $past(state == WS_ADD)); // R4

endmodule

// File: rtl/pt_walk_xlate.sv
// Module: top of the translator; joins controller and datapath.
// Assumes the processor pulses cpu_req only while cpu_busy is low.
module pt_walk_xlate
    import pt_xlate_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int OFS_W  = 12,
    localparam int PIDX_W = ADDR_W - OFS_W
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_xlate,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_busy,
    input  logic [PIDX_W-1:0] pt_origin,
    input  logic [PIDX_W-1:0] pt_length,
    output logic              exc_len,
    output logic              exc_pte,
    output logic [ADDR_W-1:0] exc_vaddr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_busy
);

    walk_ctl_t         ctl;
    logic              req_wr;
    logic              len_fault;
    logic              pte_fault;
    logic [ADDR_W-1:0] ar;
    logic [DATA_W-1:0] dr;
    logic [ADDR_W-1:0] va_q;
    logic [DATA_W-1:0] wdata_q;

    pt_walk_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_xlate (cpu_xlate),
        .req_wr    (req_wr),
        .len_fault (len_fault),
        .pte_fault (pte_fault),
        .mem_busy  (mem_busy),
        .ctl       (ctl),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .cpu_busy  (cpu_busy),
        .exc_len   (exc_len),
        .exc_pte   (exc_pte)
    );

    pt_walk_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .OFS_W  (OFS_W)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .cpu_wr    (cpu_wr),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .pt_origin (pt_origin),
        .pt_length (pt_length),
        .mem_rdata (mem_rdata),
        .req_wr    (req_wr),
        .len_fault (len_fault),
        .pte_fault (pte_fault),
        .ar        (ar),
        .dr        (dr),
        .va_q      (va_q),
        .wdata_q   (wdata_q)
    );

    // Drive the port-side views of the datapath registers
    always_comb begin
        mem_addr  = ar;
        mem_wdata = wdata_q;
        cpu_rdata = dr;
        exc_vaddr = va_q;
    end

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd || mem_wr) && mem_busy) |=> $stable(mem_addr)); // R8

endmodule

// File: tb/pt_walk_xlate_bench.sv
// Bench: vector table walked by one loop, then directed reset and busy tests.
module pt_walk_xlate_bench;

    localparam logic [1:0] OC_OK  = 2'd0;
    localparam logic [1:0] OC_LEN = 2'd1;
    localparam logic [1:0] OC_PTE = 2'd2;
    localparam int NV = 15;

    // {xlate, wr, lat[1:0], outcome[1:0], va, wdata, expected pa}
    localparam logic [101:0] VECS [NV] = '{
        {1'b1, 1'b0, 2'd0, OC_OK,  32'h0000_0010, 32'h0,          32'h0000_1010},
        {1'b1, 1'b1, 2'd2, OC_OK,  32'h0000_0ABC, 32'h1234_5678,  32'h0000_1ABC},
        {1'b1, 1'b0, 2'd1, OC_OK,  32'h0000_0ABC, 32'h0,          32'h0000_1ABC},
        {1'b1, 1'b0, 2'd3, OC_OK,  32'h0000_1234, 32'h0,          32'h0000_3234},
        {1'b1, 1'b1, 2'd1, OC_PTE, 32'h0000_1234, 32'hDEAD_BEEF,  32'h0},
        {1'b1, 1'b0, 2'd0, OC_PTE, 32'h0000_2000, 32'h0,          32'h0},
        {1'b1, 1'b0, 2'd2, OC_PTE, 32'h0000_3008, 32'h0,          32'h0},
        {1'b1, 1'b1, 2'd0, OC_OK,  32'h0000_3008, 32'hCAFE_F00D,  32'h0000_3008},
        {1'b1, 1'b0, 2'd1, OC_OK,  32'h0000_7FFC, 32'h0,          32'h0000_1FFC},
        {1'b1, 1'b0, 2'd0, OC_LEN, 32'h0000_8000, 32'h0,          32'h0},
        {1'b1, 1'b1, 2'd3, OC_LEN, 32'hFFFF_F000, 32'h0,          32'h0},
        {1'b0, 1'b0, 2'd1, OC_OK,  32'h0000_2004, 32'h0,          32'h0000_2004},
        {1'b0, 1'b1, 2'd0, OC_OK,  32'h0000_0040, 32'h0BAD_CAFE,  32'h0000_0040},
        {1'b0, 1'b0, 2'd2, OC_OK,  32'h0000_0040, 32'h0,          32'h0000_0040},
        {1'b0, 1'b0, 2'd0, OC_OK,  32'h0000_3008, 32'h0,          32'h0000_3008}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_xlate = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_busy;
    logic [19:0] pt_origin = 20'h00002;
    logic [19:0] pt_length = 20'd8;
    logic        exc_len;
    logic        exc_pte;
    logic [31:0] exc_vaddr;
    logic        mem_rd;
    logic        mem_wr;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        mem_busy;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    // cache model state
    logic [31:0] mem [4096];
    logic [1:0]  lat = 2'd0;
    logic [1:0]  lat_cnt = 2'd0;
    int          acc_cnt = 0;
    logic [31:0] last_addr = '0;
    logic [31:0] prev_addr = '0;
    logic [31:0] last_wdata = '0;

    always #5 clk = ~clk;

    pt_walk_xlate u_pt_walk_xlate (
        .clk (clk), .rst_n (rst_n), .cpu_req (cpu_req), .cpu_xlate (cpu_xlate),
        .cpu_wr (cpu_wr), .cpu_addr (cpu_addr), .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata), .cpu_busy (cpu_busy), .pt_origin (pt_origin),
        .pt_length (pt_length), .exc_len (exc_len), .exc_pte (exc_pte),
        .exc_vaddr (exc_vaddr), .mem_rd (mem_rd), .mem_wr (mem_wr),
        .mem_addr (mem_addr), .mem_wdata (mem_wdata), .mem_rdata (mem_rdata),
        .mem_busy (mem_busy)
    );

    assign mem_busy  = (mem_rd || mem_wr) && (lat_cnt != lat);
    assign mem_rdata = mem[mem_addr[13:2]];

    // Cache model: fills memory in reset, stalls lat cycles, logs accesses
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            for (int i = 0; i < 4096; i++) mem[i] <= 32'hA500_0000 | i;
            mem[12'h800] <= 32'h0000_1007;
            mem[12'h801] <= 32'h0000_3005;
            mem[12'h802] <= 32'h0000_1003;
            mem[12'h803] <= 32'h0000_3006;
            mem[12'h807] <= 32'h0000_1007;
            lat_cnt <= 2'd0;
        end else if (!(mem_rd || mem_wr)) begin
            lat_cnt <= 2'd0;
        end else if (lat_cnt != lat) begin
            lat_cnt <= lat_cnt + 2'd1;
        end else begin
            if (mem_wr) begin
                mem[mem_addr[13:2]] <= mem_wdata;
                last_wdata <= mem_wdata;
            end
            prev_addr <= last_addr;
            last_addr <= mem_addr;
            acc_cnt <= acc_cnt + 1;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Issue one request and count busy cycles; returns in first idle cycle
    task automatic issue(input logic xl, input logic wr, input logic [31:0] va,
                         input logic [31:0] wd, output int busy_cycles);
        @(negedge clk);
        cpu_xlate = xl; cpu_wr = wr; cpu_addr = va; cpu_wdata = wd; cpu_req = 1'b1;
        @(negedge clk);
        cpu_req = 1'b0;
        busy_cycles = 0;
        while (cpu_busy && busy_cycles < 64) begin
            busy_cycles++;
            @(negedge clk);
        end
    endtask

    // Watchdog
    initial begin
        wait (cyc > 20000);
        fails++;
        $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int bc;
        int acc0;
        int exp_bc;
        int exp_acc;
        logic [31:0] pte_a;
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        chk(!cpu_busy && !mem_rd && !mem_wr && !exc_len && !exc_pte, "R1 reset",
            {27'd0, cpu_busy, mem_rd, mem_wr, exc_len, exc_pte}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cpu_busy && !mem_rd && !mem_wr, "R1 after reset",
            {29'd0, cpu_busy, mem_rd, mem_wr}, 32'd0);

        for (int v = 0; v < NV; v++) begin
            logic        xl;
            logic        wr;
            logic [1:0]  oc;
            logic [31:0] va;
            logic [31:0] wd;
            logic [31:0] pa;
            xl = VECS[v][101]; wr = VECS[v][100]; lat = VECS[v][99:98];
            oc = VECS[v][97:96]; va = VECS[v][95:64]; wd = VECS[v][63:32];
            pa = VECS[v][31:0];
            pte_a = 32'h0000_2000 + {va[31:12], 2'b00};
            acc0 = acc_cnt;
            issue(xl, wr, va, wd, bc);
            case (oc)
                OC_LEN: begin exp_bc = 1; exp_acc = 0; end
                OC_PTE: begin exp_bc = int'(lat) + 3; exp_acc = 1; end
                default: begin
                    exp_bc  = xl ? 2 * int'(lat) + 4 : int'(lat) + 2;
                    exp_acc = xl ? 2 : 1;
                end
            endcase
            // R4 R5 R6 R7: busy length per outcome
            chk(bc == exp_bc, $sformatf("R6 R7 R4 R5 busy cycles v%0d", v), bc, exp_bc);
            chk((acc_cnt - acc0) == exp_acc, $sformatf("R7 R4 R5 access count v%0d", v),
                acc_cnt - acc0, exp_acc);
            chk(exc_len == (oc == OC_LEN), $sformatf("R4 exc_len v%0d", v),
                {31'd0, exc_len}, {31'd0, oc == OC_LEN});
            chk(exc_pte == (oc == OC_PTE), $sformatf("R5 exc_pte v%0d", v),
                {31'd0, exc_pte}, {31'd0, oc == OC_PTE});
            if (oc != OC_OK)
                chk(exc_vaddr == va, $sformatf("R4 R5 exc_vaddr v%0d", v), exc_vaddr, va);
            if (oc == OC_PTE)
                chk(last_addr == pte_a, $sformatf("R3 entry address v%0d", v), last_addr, pte_a);
            if (oc == OC_OK) begin
                chk(last_addr == pa, $sformatf("R6 R7 physical address v%0d", v), last_addr, pa);
                if (xl)
                    chk(prev_addr == pte_a, $sformatf("R3 entry address v%0d", v),
                        prev_addr, pte_a);
                if (wr)
                    chk(last_wdata == wd, $sformatf("R9 write data v%0d", v), last_wdata, wd);
                else
                    chk(cpu_rdata == mem[pa[13:2]], $sformatf("R9 read data v%0d", v),
                        cpu_rdata, mem[pa[13:2]]);
            end
            @(negedge clk);
            chk(!exc_len && !exc_pte, $sformatf("R10 pulse ends v%0d", v),
                {30'd0, exc_len, exc_pte}, 32'd0);
        end

        // R2: request pulse with new inputs while busy is ignored
        lat = 2'd2;
        acc0 = acc_cnt;
        @(negedge clk);
        cpu_xlate = 1'b1; cpu_wr = 1'b0; cpu_addr = 32'h0000_0010; cpu_req = 1'b1;
        @(negedge clk);
        cpu_req = 1'b0;
        @(negedge clk);
        cpu_xlate = 1'b0; cpu_wr = 1'b1; cpu_addr = 32'h0000_0044;
        cpu_wdata = 32'h7777_7777; cpu_req = 1'b1;
        @(negedge clk);
        cpu_req = 1'b0;
        bc = 0;
        while (cpu_busy && bc < 64) begin bc++; @(negedge clk); end
        chk(last_addr == 32'h0000_1010, "R2 captured address used", last_addr, 32'h0000_1010);
        chk(cpu_rdata == mem[12'h404], "R2 read data", cpu_rdata, mem[12'h404]);
        repeat (3) @(negedge clk);
        chk(!cpu_busy && (acc_cnt - acc0) == 2, "R2 no extra transaction",
            acc_cnt - acc0, 32'd2);

        // R1: reset in the middle of a walk
        lat = 2'd3;
        @(negedge clk);
        cpu_xlate = 1'b1; cpu_wr = 1'b0; cpu_addr = 32'h0000_0010; cpu_req = 1'b1;
        @(negedge clk);
        cpu_req = 1'b0;
        @(negedge clk);
        chk(mem_rd && cpu_busy, "R8 strobe during walk", {30'd0, mem_rd, cpu_busy}, 32'd3);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!cpu_busy && !mem_rd && !mem_wr && !exc_len && !exc_pte, "R1 mid-walk reset",
            {27'd0, cpu_busy, mem_rd, mem_wr, exc_len, exc_pte}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!cpu_busy, "R1 stays idle", {31'd0, cpu_busy}, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule